// File: doc/BRIEF.md
# Oscillator Stabilization Wait Controller

This block times the start-up of three clock sources: a fast source A, a slow source and a fast source B. When a source's enable rises, a counter clocked by that source counts a set number of its cycles. When the count is reached, the block reports the source as ready and raises a sticky completion flag in the bus clock domain. Software chooses the wait length for source A and for the slow source through small control registers. Source B uses a fixed wait length. Software clears each flag by writing a one to it, and a per-source enable mask combines the flags into one level interrupt.

The oscillators themselves are outside the block. Each source appears as a clock input with an enable that is synchronous to that clock. The source A inverter gain setting is only stored and driven out to the analog side. A completion inside a source domain is carried into the bus domain by a two-flop synchronizer followed by a rising-edge detector, and that edge sets the flag.

Register map (16-bit data): address 0 is the source A control, address 1 is the slow source control, address 3 holds the flags, address 4 is the interrupt enable mask, and any other address reads 0. Writes take effect at the rising bus clock edge. The read data is combinational from the read address.

Top module: `osc_settle_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, `src_ready` is 0 and `srca_gain` is 0.
- R2: The source A control register keeps the wait code in bits 1:0 and the gain code in bits 5:4. Its other bits read 0, and the gain code drives `srca_gain`.
- R3: A source A wait code c in 1..3 waits 2^(A_BASE_LOG2 + A_STEP·(c−1)) source A cycles. The flag rises no earlier than that many source cycles after the enable is sampled high.
- R4: Wait code 0 is reserved. For source A and for both slow-source modes, it selects the same count as code 3.
- R5: The slow source control register keeps the wait code in bits 1:0 and the mode in bit 4 (1 = short mode). Its other bits read 0. Code c waits 2^(BASE + STEP·(c−1)) slow cycles, using SL_BASE_LOG2/SL_STEP in normal mode and SS_BASE_LOG2/SS_STEP in short mode.
- R6: Source B always waits 2^B_LOG2 of its own cycles.
- R7: The flag register places source A in bit 2, the slow source in bit 1 and source B in bit 0. Bits 15:3 read 0, and one completion sets only its own bit.
- R8: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R9: When a completion and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: If an enable falls before its count completes, no flag is set. A new rising edge of the enable restarts the full count from zero.
- R11: `irq` is high exactly when some flag is set whose bit in the enable mask (address 4, bits 2:0, same bit order as the flags) is 1.
- R12: `src_ready[i]` goes high once source i completes and stays high while its enable is held. It returns low within a few cycles after the enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data |
| srca_clk | input | 1 | Source A clock |
| srca_en | input | 1 | Source A enable, synchronous to srca_clk |
| slow_clk | input | 1 | Slow source clock |
| slow_en | input | 1 | Slow source enable, synchronous to slow_clk |
| srcb_clk | input | 1 | Source B clock |
| srcb_en | input | 1 | Source B enable, synchronous to srcb_clk |
| srca_gain | output | 2 | Source A inverter gain code |
| src_ready | output | 3 | Per-source ready level in the bus domain (bit 2 A, bit 1 slow, bit 0 B) |
| irq | output | 1 | Combined level interrupt |

## Verification
The bench sweeps every wait code of source A and of both slow-source modes, including the reserved code, plus the fixed source B wait. For each run it measures the time from enable to flag against a window narrower than one source period. This separates every count from its neighbours and from the factor-of-four steps, and shows whether the reserved code falls back to the longest wait. A short enable pulse that drops mid-count, followed by a fresh enable, tells a held or restarted counter apart from one that wrongly completes. A run that issues a clear on every bus cycle during completion shows whether a set beats a simultaneous clear. Writes of zeros and ones to the flag and mask registers tell write-one-to-clear and interrupt masking apart from plain storage.

// File: rtl/osc_settle_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the oscillator stabilization wait controller.
// Assumes a 3-bit register address space and three sources indexed 2/1/0.
package osc_settle_pkg;
    localparam int          ADDR_W   = 3;
    localparam int          DATA_W   = 16;
    localparam int          NSRC     = 3;
    localparam int          IDX_A    = 2;
    localparam int          IDX_SLOW = 1;
    localparam int          IDX_B    = 0;
    localparam logic [2:0]  ADR_A    = 3'd0;
    localparam logic [2:0]  ADR_SLOW = 3'd1;
    localparam logic [2:0]  ADR_FLAG = 3'd3;
    localparam logic [2:0]  ADR_IE   = 3'd4;

    // Turn a 2-bit wait code into a log2 cycle count; code 0 behaves as code 3.
    function automatic int unsigned wait_log2(input logic [1:0] code,
                                              input int unsigned base,
                                              input int unsigned step);
        case (code)
            2'd1:    return base;
            2'd2:    return base + step;
            default: return base + 2 * step;
        endcase
    endfunction

    // Larger of two unsigned values.
    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/osc_settle_counter.sv
`timescale 1ns/1ps
// Per-source stabilization counter, clocked by the source clock.
// A rising edge of en restarts the count from zero. After `target` further
// source edges, done goes high and stays high while en is held. When en falls,
// done drops and the count freezes.
// Assumes en is synchronous to clk_src, target stays still while counting, and
// rst_n is held low across at least one clk_src edge.
module osc_settle_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] target,
    output logic             done
);
    logic             en_q;
    logic             busy;
    logic [CNT_W-1:0] cnt;

    // Enable edge tracking, count progress and completion level.
    always_ff @(posedge clk_src) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            en_q <= en;
            if (!en) begin
                busy <= 1'b0;
                done <= 1'b0;
            end else if (!en_q) begin
                cnt  <= '0;
                busy <= 1'b1;
                done <= 1'b0;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
                if (cnt == target - 1'b1) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R10: done never outlives the enable by more than one edge.
    assert_done_needs_en_R10: assert property (@(posedge clk_src) disable iff (!rst_n)
        !en |=> !done);
    // R3: an active count always stays below the selected length.
    assert_count_bound_R3: assert property (@(posedge clk_src) disable iff (!rst_n)
        busy |-> (cnt < target));
endmodule

// File: rtl/osc_settle_sync.sv
`timescale 1ns/1ps
// Brings a source-domain level into the bus domain through two flops. It gives
// the synchronized level and a one-cycle pulse on its rising edge.
// Assumes the input level holds for longer than two bus cycles.
module osc_settle_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic level,
    output logic rise
);
    logic s1, s2, s3;

    // Two-flop synchronizer plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= d_async;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign level = s2;
    assign rise  = s2 & ~s3;

    // R7: each completion yields a single set pulse.
    assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/osc_settle_regs.sv
`timescale 1ns/1ps
// Bus-side register file: source A control, slow source control, sticky
// write-one-to-clear flags and the interrupt mask, plus the read mux.
// Assumes set_pulse is already synchronous to clk. A set beats a clear.
module osc_settle_regs
    import osc_settle_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NSRC-1:0]   set_pulse,
    output logic [1:0]        a_wait,
    output logic [1:0]        a_gain,
    output logic [1:0]        sl_wait,
    output logic              sl_short,
    output logic [NSRC-1:0]   flags,
    output logic              irq,
    output logic [DATA_W-1:0] rd_data
);
    logic [NSRC-1:0] ie;
    logic [NSRC-1:0] clr;
    logic            unused_bits;

    assign unused_bits = ^{wr_data[15:6], wr_data[3]};
    assign clr = (wr_en && wr_addr == ADR_FLAG) ? wr_data[NSRC-1:0] : '0;

    // Control, mask and flag register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_wait   <= 2'd0;
            a_gain   <= 2'd0;
            sl_wait  <= 2'd0;
            sl_short <= 1'b0;
            ie       <= '0;
            flags    <= '0;
        end else begin
            if (wr_en && wr_addr == ADR_A) begin
                a_wait <= wr_data[1:0];
                a_gain <= wr_data[5:4];
            end
            if (wr_en && wr_addr == ADR_SLOW) begin
                sl_wait  <= wr_data[1:0];
                sl_short <= wr_data[4];
            end
            if (wr_en && wr_addr == ADR_IE) begin
                ie <= wr_data[NSRC-1:0];
            end
            flags <= (flags & ~clr) | set_pulse;
        end
    end

    // Masked flags combine into the level interrupt.
    assign irq = |(flags & ie);

    // Read mux; reserved bits and unused addresses read zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_A:    rd_data = {10'd0, a_gain, 2'd0, a_wait};
            ADR_SLOW: rd_data = {11'd0, sl_short, 2'd0, sl_wait};
            ADR_FLAG: rd_data = {{(DATA_W-NSRC){1'b0}}, flags};
            ADR_IE:   rd_data = {{(DATA_W-NSRC){1'b0}}, ie};
            default:  rd_data = '0;
        endcase
    end

    // R9: a completion in the same cycle as a clear leaves the flag set.
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pulse != '0) |=> ((flags & $past(set_pulse)) == $past(set_pulse)));
    // R8: a clear with no competing set empties the addressed flags.
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~set_pulse) != '0) |=> ((flags & $past(clr & ~set_pulse)) == '0));
endmodule

// File: rtl/osc_settle_ctrl.sv
`timescale 1ns/1ps
// Top of the oscillator stabilization wait controller. It turns the register
// codes into per-source cycle targets, runs one counter per source clock, and
// synchronizes each completion into the bus domain to set the sticky flags.
// Assumes each enable is synchronous to its own source clock, and that wait
// codes are changed only while the matching enable is low.
module osc_settle_ctrl
    import osc_settle_pkg::*;
#(
    parameter int unsigned A_BASE_LOG2  = 8,
    parameter int unsigned A_STEP       = 2,
    parameter int unsigned SL_BASE_LOG2 = 12,
    parameter int unsigned SL_STEP      = 2,
    parameter int unsigned SS_BASE_LOG2 = 3,
    parameter int unsigned SS_STEP      = 1,
    parameter int unsigned B_LOG2       = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [15:0] rd_data,
    input  logic        srca_clk,
    input  logic        srca_en,
    input  logic        slow_clk,
    input  logic        slow_en,
    input  logic        srcb_clk,
    input  logic        srcb_en,
    output logic [1:0]  srca_gain,
    output logic [2:0]  src_ready,
    output logic        irq
);
    localparam int unsigned MAX_LOG2 = umax(umax(A_BASE_LOG2 + 2 * A_STEP, B_LOG2),
                                            umax(SL_BASE_LOG2 + 2 * SL_STEP,
                                                 SS_BASE_LOG2 + 2 * SS_STEP));
    localparam int CNT_W = int'(MAX_LOG2) + 1;

    logic [1:0]                 a_wait, sl_wait;
    logic                       sl_short;
    logic [NSRC-1:0]            flags, set_pulse, done;
    logic [NSRC-1:0]            src_clk_v, src_en_v;
    logic [NSRC-1:0][CNT_W-1:0] target;
    int unsigned                lg_a, lg_s;

    assign src_clk_v = {srca_clk, slow_clk, srcb_clk};
    assign src_en_v  = {srca_en, slow_en, srcb_en};

    // Selected wait length per source, as a one-hot cycle target.
    always_comb begin
        lg_a = wait_log2(a_wait, A_BASE_LOG2, A_STEP);
        lg_s = sl_short ? wait_log2(sl_wait, SS_BASE_LOG2, SS_STEP)
                        : wait_log2(sl_wait, SL_BASE_LOG2, SL_STEP);
        target[IDX_A]    = CNT_W'(1) << lg_a;
        target[IDX_SLOW] = CNT_W'(1) << lg_s;
        target[IDX_B]    = CNT_W'(1) << B_LOG2;
    end

    osc_settle_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .set_pulse (set_pulse),
        .a_wait    (a_wait),
        .a_gain    (srca_gain),
        .sl_wait   (sl_wait),
        .sl_short  (sl_short),
        .flags     (flags),
        .irq       (irq),
        .rd_data   (rd_data)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        osc_settle_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk_src (src_clk_v[g]),
            .rst_n   (rst_n),
            .en      (src_en_v[g]),
            .target  (target[g]),
            .done    (done[g])
        );
        osc_settle_sync u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (done[g]),
            .level   (src_ready[g]),
            .rise    (set_pulse[g])
        );
    end
endmodule

// File: tb/osc_settle_ctrl_test.sv
`timescale 1ns/1ps
// Sweep bench for osc_settle_ctrl with small wait counts.
module osc_settle_ctrl_test;
    localparam int PA = 28;
    localparam int PS = 44;
    localparam int PB = 32;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        srca_clk = 1'b0, slow_clk = 1'b0, srcb_clk = 1'b0;
    logic [2:0]  en = '0;
    logic [1:0]  srca_gain;
    logic [2:0]  src_ready;
    logic        irq;
    int          total = 0, fails = 0;
    bit          over = 1'b0;

    osc_settle_ctrl #(
        .A_BASE_LOG2(2), .A_STEP(2), .SL_BASE_LOG2(2), .SL_STEP(2),
        .SS_BASE_LOG2(1), .SS_STEP(1), .B_LOG2(3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .srca_clk(srca_clk), .srca_en(en[2]), .slow_clk(slow_clk),
        .slow_en(en[1]), .srcb_clk(srcb_clk), .srcb_en(en[0]),
        .srca_gain(srca_gain), .src_ready(src_ready), .irq(irq)
    );

    always #2 clk = ~clk;
    initial begin #1; forever #(PA/2) srca_clk = ~srca_clk; end
    initial begin #1; forever #(PS/2) slow_clk = ~slow_clk; end
    initial begin #1; forever #(PB/2) srcb_clk = ~srcb_clk; end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic src_edge(input int idx);
        case (idx)
            2:       @(posedge srca_clk);
            1:       @(posedge slow_clk);
            default: @(posedge srcb_clk);
        endcase
    endtask

    function automatic int period(input int idx);
        return (idx == 2) ? PA : (idx == 1) ? PS : PB;
    endfunction

    // Expected count from a code: code 0 acts as code 3 (R4).
    function automatic int cycles(input int code, input int base, input int step);
        int c = (code == 0) ? 3 : code;
        return 1 << (base + step * (c - 1));
    endfunction

    // Enable one source, time its flag, then check ready, irq and W1C.
    task automatic measure(input int idx, input int n, input string tag);
        logic [15:0] d;
        int          p = period(idx);
        longint      t0, el;
        bit          found = 1'b0;
        wr(3'd4, 16'(1 << idx));
        rd_addr = 3'd3;
        src_edge(idx);
        #1 en[idx] = 1'b1;
        t0 = $time;
        for (int k = 0; k < (n + 4) * p / 4 + 40 && !found; k++) begin
            @(negedge clk);
            #1 if (rd_data[idx]) found = 1'b1;
        end
        el = $time - t0;
        chk(found && el >= (n + 1) * p && el <= (n + 1) * p + 22,
            {tag, " wait length"}, int'(el), (n + 1) * p);
        rd(3'd3, d);
        chk(d == 16'(1 << idx), "R7 flag position", d, 1 << idx);
        chk(irq == 1'b1, "R11 irq with mask set", irq, 1);
        chk(src_ready[idx] == 1'b1, "R12 ready while enabled", src_ready[idx], 1);
        wr(3'd4, 16'h0);
        #1 chk(irq == 1'b0, "R11 irq masked off", irq, 0);
        en[idx] = 1'b0;
        repeat (3) src_edge(idx);
        @(negedge clk); @(negedge clk);
        #1 chk(src_ready[idx] == 1'b0, "R12 ready after disable", src_ready[idx], 0);
        wr(3'd3, 16'h0);
        rd(3'd3, d);
        chk(d == 16'(1 << idx), "R8 write 0 keeps flag", d, 1 << idx);
        wr(3'd3, 16'(1 << idx));
        rd(3'd3, d);
        chk(d == 16'h0, "R8 write 1 clears flag", d, 0);
    endtask

    initial begin : watchdog
        #700000;
        if (!over) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] d;
        bit          seen;
        repeat (30) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk(d == 16'h0, "R1 register reset", d, 0);
        end
        chk(irq == 1'b0, "R1 irq reset", irq, 0);
        chk(src_ready == 3'b0, "R1 ready reset", src_ready, 0);
        chk(srca_gain == 2'd0, "R1 gain reset", srca_gain, 0);
        // R2 source A layout
        wr(3'd0, 16'hFFFF); rd(3'd0, d);
        chk(d == 16'h0033, "R2 A ctrl reserved bits", d, 16'h33);
        chk(srca_gain == 2'd3, "R2 gain output", srca_gain, 3);
        wr(3'd0, 16'h0021); rd(3'd0, d);
        chk(d == 16'h0021 && srca_gain == 2'd2, "R2 A ctrl fields", d, 16'h21);
        // R5 slow layout; R7 flag reserved bits
        wr(3'd1, 16'hFFFF); rd(3'd1, d);
        chk(d == 16'h0013, "R5 slow ctrl reserved bits", d, 16'h13);
        wr(3'd3, 16'hFFFF); rd(3'd3, d);
        chk(d == 16'h0, "R7 flag reserved bits", d, 0);
        // R3, R4 source A sweep
        for (int c = 0; c < 4; c++) begin
            wr(3'd0, 16'(c));
            measure(2, cycles(c, 2, 2), (c == 0) ? "R4 A reserved code" : "R3 A code");
        end
        // R5, R4 slow source sweep, both modes
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 4; c++) begin
                wr(3'd1, 16'((m << 4) | c));
                measure(1, (m == 1) ? cycles(c, 1, 1) : cycles(c, 2, 2),
                        (c == 0) ? "R4 slow reserved code" : "R5 slow code");
            end
        end
        // R6 source B
        measure(0, 8, "R6 B fixed");
        // R10 enable dropped mid-count, then restart
        wr(3'd0, 16'h3);
        src_edge(2); #1 en[2] = 1'b1;
        repeat (10) src_edge(2);
        #1 en[2] = 1'b0;
        repeat (100) src_edge(2);
        rd(3'd3, d);
        chk(d == 16'h0, "R10 no flag after early drop", d, 0);
        chk(src_ready[2] == 1'b0, "R10 not ready after early drop", src_ready[2], 0);
        measure(2, 64, "R10 restart full count");
        // R9 set beats a clear issued every cycle
        seen = 1'b0;
        rd_addr = 3'd3;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'h0007;
        src_edge(0); #1 en[0] = 1'b1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            #1 if (rd_data[0]) seen = 1'b1;
        end
        wr_en = 1'b0;
        chk(seen, "R9 set wins over clear", seen, 1);
        en[0] = 1'b0;
        repeat (3) src_edge(0);
        wr(3'd3, 16'h7);
        rd(3'd3, d);
        chk(d == 16'h0, "R8 clear after contention", d, 0);
        over = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule